// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small 32-bit in-order integer core that is split into five stages: fetch, decode, execute, memory access and writeback. It runs a reduced register-to-register instruction subset. The subset covers four R-format arithmetic and logic operations, a word load, a word store and a branch-on-equal. Instruction storage and data storage are separate word-organised RAMs inside the block. Each RAM has a load port, which the environment uses to fill it while reset is held.

Four pipeline registers separate the five stages. The program counter and every pipeline register update on every clock. Decode produces all control once. The control then travels with the instruction in three bundles: execute, memory and writeback. Each bundle is discarded after the stage that uses it. There is no hazard detection, forwarding or squashing, so software must keep dependent instructions at least three slots apart. The three slots that follow a branch always run. The only same-cycle relief is inside the register file: a read that meets a writeback to the same register returns the value being written.

Two debug taps are the only outputs. One shows the fetch address. The other shows the register-file write port: enable, register number and data.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted, `dbg_pc` is 0 and `dbg_wb_en` is 0. After reset is released, no write appears on the write tap before the first fetched instruction reaches writeback.
- R2: When no branch is taken, `dbg_pc` rises by 4 on every clock after reset is released.
- R3: An instruction fetched in cycle n appears on the write tap in cycle n+4.
- R4: Opcode 0 (bits 31:26) selects the R-format, and the function field (bits 5:0) picks the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. The operands come from register fields bits 25:21 and 20:16, and the result is written to the register in bits 15:11.
- R5: Opcode 0x23 loads a word. The byte address is the register in bits 25:21 plus the sign-extended immediate in bits 15:0. The word index is that address shifted right by 2. The loaded value goes to the register in bits 20:16.
- R6: Opcode 0x2B stores the register in bits 20:16 at the address formed as in R5, and causes no register write.
- R7: Opcode 0x04 compares the two source registers. If they are equal, the fetch address four cycles after the branch was fetched is the branch's own address + 4 + (sign-extended immediate × 4). The three instructions fetched after the branch still complete. If they are not equal, fetch continues in sequence.
- R8: When an instruction reads a register in decode during the same cycle that writeback writes that register, it receives the new value.
- R9: Register 0 always reads as 0. A write aimed at register 0 never appears on the write tap and has no effect.
- R10: With register i holding i+100 and every data word holding 99, the five instructions fetched from byte address 1000 are: load $8 from 4($29), subtract $2=$4−$5, AND $9=$10&$11, OR $16=$17|$18, add $13=$14+$0. They write 99, 0xFFFFFFFF, 110, 119 and 114 on five consecutive cycles, starting four cycles after the load is fetched.
- R11: An opcode outside {0x00, 0x23, 0x2B, 0x04} writes no register, stores nothing and does not redirect fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_ld_we | input | 1 | Write strobe for the instruction RAM load port |
| imem_ld_addr | input | $clog2(IMEM_WORDS) | Word index for the instruction load |
| imem_ld_data | input | 32 | Instruction word to store |
| dmem_ld_we | input | 1 | Write strobe for the data RAM load port |
| dmem_ld_addr | input | $clog2(DMEM_WORDS) | Word index for the data load |
| dmem_ld_data | input | 32 | Data word to store |
| dbg_pc | output | 32 | Current fetch byte address |
| dbg_wb_en | output | 1 | Register-file write enable in writeback |
| dbg_wb_reg | output | 5 | Register number being written |
| dbg_wb_data | output | 32 | Value being written |

## Verification
The properties assume that the program contains no read-after-write pair closer than three slots. They also assume that both load ports are used only while reset is held, so the store path never competes with a load-port write. The stimulus follows both rules. It fills the RAMs before releasing reset. It pads every producer–consumer pair to a distance of exactly three, so the decode-read bypass is exercised without relying on forwarding that does not exist. The three slots after each branch hold instructions whose results are expected.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int REG_AW = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    alu_src;
    alu_op_e alu_op;
  } ex_ctrl_t;

  typedef struct packed {
    logic mem_read;
    logic mem_write;
    logic branch;
  } mem_ctrl_t;

  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0]   pc4;
    logic [XLEN-1:0]   opa;
    logic [XLEN-1:0]   opb;
    logic [XLEN-1:0]   imm;
    logic [REG_AW-1:0] dest;
    ex_ctrl_t          ex;
    mem_ctrl_t         mem;
    wb_ctrl_t          wb;
  } idex_t;

  typedef struct packed {
    logic [XLEN-1:0]   alu_res;
    logic [XLEN-1:0]   st_data;
    logic [XLEN-1:0]   br_target;
    logic              zero;
    logic [REG_AW-1:0] dest;
    mem_ctrl_t         mem;
    wb_ctrl_t          wb;
  } exmem_t;

  typedef struct packed {
    logic [XLEN-1:0]   alu_res;
    logic [REG_AW-1:0] dest;
    wb_ctrl_t          wb;
  } memwb_t;
endpackage

// File: rtl/pipe5_ram.sv
module pipe5_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; output register has a synchronous reset
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0]   instr,
  output logic [REG_AW-1:0] rs,
  output logic [REG_AW-1:0] rt,
  output logic [REG_AW-1:0] dest,
  output logic [XLEN-1:0]   imm_ext,
  output ex_ctrl_t          ex,
  output mem_ctrl_t         mem,
  output wb_ctrl_t          wb
);
  logic [5:0]        opcode;
  logic [5:0]        funct;
  logic [REG_AW-1:0] rd;

  assign opcode  = instr[31:26];
  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign funct   = instr[5:0];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  always_comb begin
    ex   = '0;
    mem  = '0;
    wb   = '0;
    dest = '0;
    unique case (opcode)
      OP_RTYPE: begin
        dest         = rd;
        wb.reg_write = (rd != '0);
        case (funct)
          FN_SUB:  ex.alu_op = ALU_SUB;
          FN_AND:  ex.alu_op = ALU_AND;
          FN_OR:   ex.alu_op = ALU_OR;
          default: ex.alu_op = ALU_ADD;
        endcase
      end
      OP_LOAD: begin
        dest          = rt;
        ex.alu_src    = 1'b1;
        mem.mem_read  = 1'b1;
        wb.reg_write  = (rt != '0);
        wb.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ex.alu_src    = 1'b1;
        mem.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ex.alu_op  = ALU_SUB;
        mem.branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] regs [1:NREGS-1];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  // write-before-read: a same-cycle write is visible to the read ports
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)                  rdata[p] = '0;
      else if (we && waddr == raddr[p])    rdata[p] = wdata;
      else                                 rdata[p] = regs[raddr[p]];
    end
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 512,
  parameter int DMEM_WORDS = 256,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imem_ld_we,
  input  logic [IAW-1:0]    imem_ld_addr,
  input  logic [XLEN-1:0]   imem_ld_data,
  input  logic              dmem_ld_we,
  input  logic [DAW-1:0]    dmem_ld_addr,
  input  logic [XLEN-1:0]   dmem_ld_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wb_en,
  output logic [REG_AW-1:0] dbg_wb_reg,
  output logic [XLEN-1:0]   dbg_wb_data
);
  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q, pc_plus4, pc_next;
  logic [XLEN-1:0] ifid_instr, ifid_pc4_q;
  logic            take_branch;
  exmem_t          exmem_q, exmem_d;
  idex_t           idex_q, idex_d;
  memwb_t          memwb_q, memwb_d;
  logic [XLEN-1:0] wb_data;

  assign pc_plus4    = pc_q + XLEN'(4);
  assign take_branch = exmem_q.mem.branch & exmem_q.zero;
  assign pc_next     = take_branch ? exmem_q.br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) ifid_pc4_q <= pc_plus4;

  // instruction RAM output register doubles as the IF/ID instruction field
  pipe5_ram #(.WIDTH(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .rst   (rst),
    .we    (imem_ld_we),
    .waddr (imem_ld_addr),
    .wdata (imem_ld_data),
    .re    (1'b1),
    .raddr (pc_q[IAW+1:2]),
    .rdata (ifid_instr)
  );

  // ---------------- decode ----------------
  logic [REG_AW-1:0]           id_rs, id_rt, id_dest;
  logic [XLEN-1:0]             id_imm;
  ex_ctrl_t                    id_ex;
  mem_ctrl_t                   id_mem;
  wb_ctrl_t                    id_wb;
  logic [1:0][REG_AW-1:0]      rf_raddr;
  logic [1:0][XLEN-1:0]        rf_rdata;

  pipe5_decode u_dec (
    .instr   (ifid_instr),
    .rs      (id_rs),
    .rt      (id_rt),
    .dest    (id_dest),
    .imm_ext (id_imm),
    .ex      (id_ex),
    .mem     (id_mem),
    .wb      (id_wb)
  );

  assign rf_raddr[0] = id_rs;
  assign rf_raddr[1] = id_rt;

  pipe5_regfile #(.W(XLEN), .NREGS(NREGS), .NRD(2)) u_rf (
    .clk   (clk),
    .we    (memwb_q.wb.reg_write),
    .waddr (memwb_q.dest),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  always_comb begin
    idex_d      = '0;
    idex_d.pc4  = ifid_pc4_q;
    idex_d.opa  = rf_rdata[0];
    idex_d.opb  = rf_rdata[1];
    idex_d.imm  = id_imm;
    idex_d.dest = id_dest;
    idex_d.ex   = id_ex;
    idex_d.mem  = id_mem;
    idex_d.wb   = id_wb;
  end

  always_ff @(posedge clk) begin
    idex_q <= idex_d;
    if (rst) begin
      idex_q.ex  <= '0;
      idex_q.mem <= '0;
      idex_q.wb  <= '0;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_zero;

  assign alu_b = idex_q.ex.alu_src ? idex_q.imm : idex_q.opb;

  pipe5_alu #(.W(XLEN)) u_alu (
    .a    (idex_q.opa),
    .b    (alu_b),
    .op   (idex_q.ex.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    exmem_d           = '0;
    exmem_d.alu_res   = alu_y;
    exmem_d.st_data   = idex_q.opb;
    exmem_d.br_target = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};
    exmem_d.zero      = alu_zero;
    exmem_d.dest      = idex_q.dest;
    exmem_d.mem       = idex_q.mem;
    exmem_d.wb        = idex_q.wb;
  end

  always_ff @(posedge clk) begin
    exmem_q <= exmem_d;
    if (rst) begin
      exmem_q.mem <= '0;
      exmem_q.wb  <= '0;
    end
  end

  // ---------------- memory ----------------
  logic              dm_we;
  logic [DAW-1:0]    dm_waddr;
  logic [XLEN-1:0]   dm_wdata;
  logic [XLEN-1:0]   mem_rdata;

  assign dm_we    = dmem_ld_we | exmem_q.mem.mem_write;
  assign dm_waddr = dmem_ld_we ? dmem_ld_addr : exmem_q.alu_res[DAW+1:2];
  assign dm_wdata = dmem_ld_we ? dmem_ld_data : exmem_q.st_data;

  // data RAM output register doubles as the MEM/WB read-data field
  pipe5_ram #(.WIDTH(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .rst   (rst),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .re    (exmem_q.mem.mem_read),
    .raddr (exmem_q.alu_res[DAW+1:2]),
    .rdata (mem_rdata)
  );

  always_comb begin
    memwb_d         = '0;
    memwb_d.alu_res = exmem_q.alu_res;
    memwb_d.dest    = exmem_q.dest;
    memwb_d.wb      = exmem_q.wb;
  end

  always_ff @(posedge clk) begin
    memwb_q <= memwb_d;
    if (rst) memwb_q.wb <= '0;
  end

  // ---------------- writeback ----------------
  assign wb_data = memwb_q.wb.mem_to_reg ? mem_rdata : memwb_q.alu_res;

  assign dbg_pc      = pc_q;
  assign dbg_wb_en   = memwb_q.wb.reg_write;
  assign dbg_wb_reg  = memwb_q.dest;
  assign dbg_wb_data = wb_data;

  // flat views for the bound checker
  logic            chk_store_mem;
  logic [XLEN-1:0] chk_br_target;
  logic [REG_AW-1:0] chk_id_rs;
  logic [XLEN-1:0] chk_id_opa;
  assign chk_store_mem = exmem_q.mem.mem_write;
  assign chk_br_target = exmem_q.br_target;
  assign chk_id_rs     = id_rs;
  assign chk_id_opa    = rf_rdata[0];
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
  import pipe5_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   pc,
  input logic              take_branch,
  input logic [XLEN-1:0]   br_target,
  input logic              store_mem,
  input logic              wb_en,
  input logic [REG_AW-1:0] wb_reg,
  input logic [XLEN-1:0]   wb_data,
  input logic [REG_AW-1:0] id_rs,
  input logic [XLEN-1:0]   id_opa
);
  assert_reset_release_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0 && !wb_en));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !take_branch |=> pc == $past(pc) + XLEN'(4));

  assert_store_silent_R6: assert property (@(posedge clk) disable iff (rst)
    store_mem |=> !wb_en);

  assert_branch_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> pc == $past(br_target));

  assert_same_cycle_read_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_reg == id_rs) |-> id_opa == wb_data);

  assert_zero_read_R9: assert property (@(posedge clk) disable iff (rst)
    (id_rs == '0) |-> id_opa == '0);

  assert_no_zero_write_R9: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> wb_reg != '0);
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (dbg_pc),
  .take_branch (take_branch),
  .br_target   (chk_br_target),
  .store_mem   (chk_store_mem),
  .wb_en       (dbg_wb_en),
  .wb_reg      (dbg_wb_reg),
  .wb_data     (dbg_wb_data),
  .id_rs       (chk_id_rs),
  .id_opa      (chk_id_opa)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb_top;
  localparam int IMEM_WORDS = 512;
  localparam int DMEM_WORDS = 256;
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int NSAMP = 80;
  localparam int MAXLOG = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            imem_ld_we = 1'b0;
  logic [IAW-1:0]  imem_ld_addr = '0;
  logic [31:0]     imem_ld_data = '0;
  logic            dmem_ld_we = 1'b0;
  logic [DAW-1:0]  dmem_ld_addr = '0;
  logic [31:0]     dmem_ld_data = '0;
  logic [31:0]     dbg_pc;
  logic            dbg_wb_en;
  logic [4:0]      dbg_wb_reg;
  logic [31:0]     dbg_wb_data;

  always #10 clk = ~clk;

  pipe5_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) dut_i (
    .clk(clk), .rst(rst),
    .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dbg_pc(dbg_pc), .dbg_wb_en(dbg_wb_en), .dbg_wb_reg(dbg_wb_reg), .dbg_wb_data(dbg_wb_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] prog [IMEM_WORDS];
  logic [31:0] pc_tr [NSAMP];
  int          log_cnt = 0;
  logic [4:0]  log_reg [MAXLOG];
  logic [31:0] log_dat [MAXLOG];
  int          log_n   [MAXLOG];
  int          exp_cnt = 0;
  logic [4:0]  exp_reg [MAXLOG];
  logic [31:0] exp_dat [MAXLOG];
  int          exp_n   [MAXLOG];
  string       exp_req [MAXLOG];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    logic [4:0] a = rs[4:0], b = rt[4:0], d = rd[4:0];
    return {6'h00, a, b, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    logic [4:0] a = rs[4:0], b = rt[4:0];
    logic [15:0] k = imm[15:0];
    return {op, a, b, k};
  endfunction

  task automatic expect_wb(int r, logic [31:0] d, int n, string req);
    exp_reg[exp_cnt] = r[4:0];
    exp_dat[exp_cnt] = d;
    exp_n[exp_cnt]   = n;
    exp_req[exp_cnt] = req;
    exp_cnt++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    // ---- program image ----
    for (int i = 0; i < IMEM_WORDS; i++) prog[i] = 32'h0;
    for (int k = 1; k < 32; k++) begin
      prog[k-1] = enc_i(6'h23, 0, k, 4*k);           // R5: load $k from word k
      expect_wb(k, 32'(k + 100), k + 3, "R5");
    end
    prog[34] = enc_i(6'h2B, 0, 7, 200);              // R6: store $7 to word 50
    prog[35] = enc_i(6'h3F, 0, 3, 200);              // R11: unknown opcode
    prog[37] = enc_i(6'h23, 0, 20, 200);             // R6/R11: read word 50 back
    expect_wb(20, 32'd107, 41, "R6");
    prog[38] = enc_r(1, 2, 0, 6'h20);                // R9: write to $0 suppressed
    prog[39] = enc_r(5, 3, 21, 6'h22);               // R4 sub
    expect_wb(21, 32'd2, 43, "R4");
    prog[40] = enc_r(12, 13, 22, 6'h24);             // R4 and
    expect_wb(22, 32'd112, 44, "R4");
    prog[41] = enc_r(12, 3, 23, 6'h25);              // R4 or
    expect_wb(23, 32'd119, 45, "R4");
    prog[42] = enc_r(21, 0, 24, 6'h20);              // R8 same-cycle read, R9 $0 reads 0
    expect_wb(24, 32'd2, 46, "R8");
    prog[43] = enc_i(6'h04, 1, 2, 5);                // R7 not taken
    prog[44] = enc_i(6'h23, 26, 25, -4);             // R5 negative offset
    expect_wb(25, 32'd130, 48, "R5");
    prog[45] = enc_i(6'h04, 3, 3, 204);              // R7 taken to byte 1000
    prog[46] = enc_r(1, 1, 26, 6'h20);               // R7 slot 1
    expect_wb(26, 32'd202, 50, "R7");
    prog[47] = enc_r(2, 2, 27, 6'h20);               // R7 slot 2
    expect_wb(27, 32'd204, 51, "R7");
    prog[48] = enc_r(3, 3, 28, 6'h20);               // R7 slot 3
    expect_wb(28, 32'd206, 52, "R7");
    prog[49] = enc_r(1, 1, 30, 6'h20);               // must never be fetched
    prog[250] = enc_i(6'h23, 29, 8, 4);              // R10 sequence
    prog[251] = enc_r(4, 5, 2, 6'h22);
    prog[252] = enc_r(10, 11, 9, 6'h24);
    prog[253] = enc_r(17, 18, 16, 6'h25);
    prog[254] = enc_r(14, 0, 13, 6'h20);
    expect_wb(8,  32'd99,        53, "R10");
    expect_wb(2,  32'hFFFF_FFFF, 54, "R10");
    expect_wb(9,  32'd110,       55, "R10");
    expect_wb(16, 32'd119,       56, "R10");
    expect_wb(13, 32'd114,       57, "R10");

    // ---- fill RAMs under reset ----
    for (int i = 0; i < IMEM_WORDS; i++) begin
      @(negedge clk);
      imem_ld_we = 1'b1; imem_ld_addr = IAW'(i); imem_ld_data = prog[i];
    end
    for (int i = 0; i < DMEM_WORDS; i++) begin
      @(negedge clk);
      dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(i);
      dmem_ld_data = (i >= 1 && i < 32) ? 32'(i + 100) : 32'd99;
    end
    @(negedge clk);
    imem_ld_we = 1'b0; dmem_ld_we = 1'b0;
    @(negedge clk);
    check(dbg_pc == 32'h0, "R1", "pc in reset", dbg_pc, 32'h0);
    check(dbg_wb_en == 1'b0, "R1", "write tap in reset", 32'(dbg_wb_en), 32'h0);

    // ---- run and record ----
    rst = 1'b0;
    for (int n = 0; n < NSAMP; n++) begin
      pc_tr[n] = dbg_pc;
      if (dbg_wb_en && log_cnt < MAXLOG) begin
        log_reg[log_cnt] = dbg_wb_reg;
        log_dat[log_cnt] = dbg_wb_data;
        log_n[log_cnt]   = n;
        log_cnt++;
      end
      @(negedge clk);
    end

    // ---- fetch address trace ----
    for (int n = 0; n < 49; n++)
      check(pc_tr[n] == 32'(4 * n), (n == 44) ? "R7" : "R2", "sequential pc", pc_tr[n], 32'(4 * n));
    for (int n = 49; n < 54; n++)
      check(pc_tr[n] == 32'(1000 + 4 * (n - 49)), "R7", "pc after taken branch",
            pc_tr[n], 32'(1000 + 4 * (n - 49)));

    // ---- writeback log ----
    check(log_cnt == exp_cnt, "R11", "write count (R9 R7 too)", 32'(log_cnt), 32'(exp_cnt));
    check(log_cnt > 0 && log_n[0] == 4, "R1", "first write cycle", 32'(log_n[0]), 32'd4);
    for (int i = 0; i < exp_cnt && i < log_cnt; i++) begin
      check(log_reg[i] == exp_reg[i], exp_req[i], "write register", 32'(log_reg[i]), 32'(exp_reg[i]));
      check(log_dat[i] == exp_dat[i], exp_req[i], "write data", log_dat[i], exp_dat[i]);
      check(log_n[i] == exp_n[i], "R3", "write cycle", 32'(log_n[i]), 32'(exp_n[i]));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule